// File: doc/BRIEF.md
# Phase-Frequency Detector with Pump Control and Power-Down Sequencing

This block is the digital core of one synthesizer loop. It compares a divided reference signal against a divided oscillator signal and turns the difference into pump-up and pump-down requests. The comparison uses two edge-set flags that clear together.

Around this comparator, configuration inputs control how the requests reach the charge pump. One input swaps up and down to match the oscillator's tuning slope. Another forces the pump into high impedance. A 3-bit code sets the pump current, from 0.625 mA at code 000 to 5.0 mA at code 111 in equal 0.625 mA steps. A fastlock input overrides that code to full current and closes an extra damping switch.

A power-down input shuts the loop down. When the pump is active, shutdown is a sequence: no new pulses start, the running pulse finishes, the pump goes to high impedance for one cycle, and only then is the section marked off. When the pump is already in high impedance, the section goes off at once. While off, the loop dividers are told to hold their load state. The shared reference oscillator enable drops only when this loop and its neighbour loop are both off. All inputs are sampled on `clk`, and the divided signals are levels whose rising edges count.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: A rising edge on `ref_div_in` that is sampled at a clock edge sets the internal UP flag after that edge. A rising edge on `vco_div_in` sets the DOWN flag the same way. A set flag stays set until the pair clears.
- R2: When both flags are set at a clock edge, both read 0 after that edge.
- R3: With `cfg_polarity`=1, `pump_up` shows UP and `pump_dn` shows DOWN. With `cfg_polarity`=0, the two are swapped.
- R4: While `cfg_tristate`=1, `pump_en`, `pump_up` and `pump_dn` are all 0.
- R5: With `cfg_fastlock`=0, `cur_code` equals `cfg_cur_code`, and `fastlock_sw` is 0. Code 000 means 0.625 mA and code 111 means 5.0 mA.
- R6: With `cfg_fastlock`=1, `cur_code` is 111 and `fastlock_sw` is 1. Clearing the input restores the programmed code in the same cycle.
- R7: When `cfg_pwrdn` rises while `cfg_tristate`=0, no new pulse may start. A pulse already running goes on to completion. At the first edge that finds both flags clear, `pump_en` drops. At the following edge, `section_off` and `div_hold` rise.
- R8: When `cfg_pwrdn`=1 and `cfg_tristate`=1, `section_off` and `div_hold` are 1 in the same cycle, with no clock edge needed.
- R9: Driving `cfg_pwrdn` to 0 clears `section_off` and `div_hold` in the same cycle.
- R10: `ref_osc_en` is 0 exactly when `section_off`=1 and `other_loop_off`=1.
- R11: While `section_off`=1, both flags are held clear and edges are ignored, so no pulse is pending once power returns.
- R12: After a synchronous reset, both pump outputs are 0, `section_off` is 0, and `pump_en` is 1 when `cfg_tristate`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_div_in | input | 1 | Divided reference level |
| vco_div_in | input | 1 | Divided oscillator level |
| cfg_polarity | input | 1 | 1 = positive tuning slope, 0 = swap up and down |
| cfg_tristate | input | 1 | Force the pump to high impedance |
| cfg_cur_code | input | 3 | Programmed pump current code |
| cfg_fastlock | input | 1 | Fastlock override |
| cfg_pwrdn | input | 1 | Power-down request for this loop |
| other_loop_off | input | 1 | The neighbour loop is powered down |
| pump_up | output | 1 | Pump source request |
| pump_dn | output | 1 | Pump sink request |
| pump_en | output | 1 | Pump driven (0 = high impedance) |
| cur_code | output | 3 | Effective current code |
| fastlock_sw | output | 1 | Extra damping switch closed |
| div_hold | output | 1 | Hold the R and N dividers in their load state |
| section_off | output | 1 | This loop is powered down |
| ref_osc_en | output | 1 | Shared reference oscillator enable |

## Verification
The hardest situation to reach is a synchronous power-down that arrives while a pulse is half done. The shutdown must wait through that pulse, and it must not let a fresh reference edge start another one. To get there, the stimulus opens a pulse with a reference edge and raises the power-down input in the next cycle. It holds that state for several cycles, then completes the pulse with an oscillator edge. The outputs are then checked at each edge through the drain, three-state and off steps. A second run raises power-down in the same cycle as a reference edge, to show that no pulse starts.

// File: rtl/pfd_pkg.sv
// Shared types for the phase-frequency detector control block.
package pfd_pkg;
    // Power-down sequencer states.
    typedef enum logic [1:0] {
        SEQ_RUN   = 2'd0,   // normal operation
        SEQ_DRAIN = 2'd1,   // waiting for the running pulse to end
        SEQ_TRI   = 2'd2,   // pump three-stated, section still up
        SEQ_OFF   = 2'd3    // section powered down
    } seq_state_t;
endpackage

// File: rtl/pfd_core.sv
// Edge-triggered phase-frequency detector.
// Each divided input is a level; its rising edge, seen at a clock edge, sets
// a flag. When both flags are set, both clear at the next edge.
// Assumes inputs are already synchronous to clk.
module pfd_core (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic vco_in,
    input  logic block_new,   // no new pulse may start
    input  logic hold,        // force both flags clear
    output logic up_q,
    output logic dn_q
);
    logic ref_d, vco_d;
    logic ref_rise, vco_rise;
    logic pair_clr;
    logic set_up, set_dn;

    assign ref_rise = ref_in & ~ref_d;
    assign vco_rise = vco_in & ~vco_d;
    assign pair_clr = up_q & dn_q;
    // a blocked edge may only finish a pulse the other flag opened
    assign set_up   = ref_rise & (~block_new | dn_q);
    assign set_dn   = vco_rise & (~block_new | up_q);

    // Delay registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_d <= 1'b0;
            vco_d <= 1'b0;
        end else begin
            ref_d <= ref_in;
            vco_d <= vco_in;
        end
    end

    // The UP/DOWN flag pair with its shared clear.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || pair_clr) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_q | set_up;
            dn_q <= dn_q | set_dn;
        end
    end

    a_r2_pair_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && dn_q) |=> (!up_q && !dn_q));
    a_r11_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!up_q && !dn_q));
    a_r1_up_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_in && !ref_d && !block_new && !hold && !(up_q && dn_q)) |=> up_q);
endmodule

// File: rtl/pd_sequencer.sv
// Power-down sequencer for one loop.
// With the pump active, shutdown drains the running pulse, three-states the
// pump for one cycle, then marks the section off. With the pump already
// three-stated, the section goes off at once. Clearing the request restores
// operation in the same cycle.
module pd_sequencer
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic tri_cfg,
    input  logic pfd_busy,
    output logic tri_seq,
    output logic section_off
);
    seq_state_t st, st_nxt;

    // Next-state choice.
    always_comb begin
        st_nxt = st;
        if (!pd_req) begin
            st_nxt = SEQ_RUN;
        end else begin
            case (st)
                SEQ_RUN:   st_nxt = tri_cfg ? SEQ_OFF : SEQ_DRAIN;
                SEQ_DRAIN: begin
                    if (tri_cfg)       st_nxt = SEQ_OFF;
                    else if (!pfd_busy) st_nxt = SEQ_TRI;
                end
                SEQ_TRI:   st_nxt = SEQ_OFF;
                default:   st_nxt = SEQ_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SEQ_RUN;
        else        st <= st_nxt;
    end

    assign tri_seq     = pd_req & (st == SEQ_TRI);
    assign section_off = pd_req & (tri_cfg | (st == SEQ_OFF));

    a_r7_tri_then_off: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_TRI && pd_req) |=> (section_off || !pd_req));
    a_r7_drain_busy_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_DRAIN && pd_req && !tri_cfg && pfd_busy) |=> !section_off);
endmodule

// File: rtl/pump_drive.sv
// Output stage: applies polarity, three-state gating and the current override.
// Pure combinational; assumes the flags come from pfd_core.
module pump_drive #(
    parameter int CUR_W = 3
) (
    input  logic             polarity,
    input  logic             tri_cfg,
    input  logic             tri_seq,
    input  logic             section_off,
    input  logic             up_q,
    input  logic             dn_q,
    input  logic [CUR_W-1:0] cur_cfg,
    input  logic             fastlock,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             pump_en,
    output logic [CUR_W-1:0] cur_code,
    output logic             fl_sw
);
    localparam logic [CUR_W-1:0] CUR_MAX = {CUR_W{1'b1}};

    logic src, snk;

    // Polarity mapping of the flag pair onto source and sink.
    always_comb begin
        src = polarity ? up_q : dn_q;
        snk = polarity ? dn_q : up_q;
    end

    // Gate the pump and pick the effective current code.
    always_comb begin
        pump_en  = ~tri_cfg & ~tri_seq & ~section_off;
        pump_up  = pump_en & src;
        pump_dn  = pump_en & snk;
        cur_code = fastlock ? CUR_MAX : cur_cfg;
        fl_sw    = fastlock;
    end
endmodule

// File: rtl/pfd_pump_ctrl.sv
// Top of the phase-frequency detector and pump control for one loop.
// Connects the detector, the power-down sequencer and the output stage, and
// drives the shared reference oscillator enable. Assumes all inputs are
// synchronous to clk; reset is synchronous and active low.
module pfd_pump_ctrl #(
    parameter int CUR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_div_in,
    input  logic             vco_div_in,
    input  logic             cfg_polarity,
    input  logic             cfg_tristate,
    input  logic [CUR_W-1:0] cfg_cur_code,
    input  logic             cfg_fastlock,
    input  logic             cfg_pwrdn,
    input  logic             other_loop_off,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             pump_en,
    output logic [CUR_W-1:0] cur_code,
    output logic             fastlock_sw,
    output logic             div_hold,
    output logic             section_off,
    output logic             ref_osc_en
);
    logic up_q, dn_q;
    logic tri_seq;
    logic off_i;

    pfd_core i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_div_in),
        .vco_in    (vco_div_in),
        .block_new (cfg_pwrdn),
        .hold      (off_i),
        .up_q      (up_q),
        .dn_q      (dn_q)
    );

    pd_sequencer i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_req      (cfg_pwrdn),
        .tri_cfg     (cfg_tristate),
        .pfd_busy    (up_q | dn_q),
        .tri_seq     (tri_seq),
        .section_off (off_i)
    );

    pump_drive #(.CUR_W(CUR_W)) i_drive (
        .polarity    (cfg_polarity),
        .tri_cfg     (cfg_tristate),
        .tri_seq     (tri_seq),
        .section_off (off_i),
        .up_q        (up_q),
        .dn_q        (dn_q),
        .cur_cfg     (cfg_cur_code),
        .fastlock    (cfg_fastlock),
        .pump_up     (pump_up),
        .pump_dn     (pump_dn),
        .pump_en     (pump_en),
        .cur_code    (cur_code),
        .fl_sw       (fastlock_sw)
    );

    // Section status, divider hold and the shared oscillator enable.
    always_comb begin
        section_off = off_i;
        div_hold    = off_i;
        ref_osc_en  = ~(off_i & other_loop_off);
    end

    a_r4_tristate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_tristate |-> (!pump_up && !pump_dn && !pump_en));
    a_r6_fastlock_max: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fastlock |-> (cur_code == {CUR_W{1'b1}} && fastlock_sw));
    a_r11_off_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        section_off |-> (!pump_up && !pump_dn));
endmodule

// File: tb/test_pfd_pump_ctrl.sv
// Directed bench for pfd_pump_ctrl. Inputs change on falling edges; outputs are
// sampled on falling edges.
module test_pfd_pump_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_div_in = 1'b0, vco_div_in = 1'b0;
    logic       cfg_polarity = 1'b1, cfg_tristate = 1'b0;
    logic [2:0] cfg_cur_code = 3'd0;
    logic       cfg_fastlock = 1'b0, cfg_pwrdn = 1'b0, other_loop_off = 1'b0;
    logic       pump_up, pump_dn, pump_en, fastlock_sw, div_hold, section_off, ref_osc_en;
    logic [2:0] cur_code;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    pfd_pump_ctrl i_pfd_pump_ctrl (
        .clk(clk), .rst_n(rst_n), .ref_div_in(ref_div_in), .vco_div_in(vco_div_in),
        .cfg_polarity(cfg_polarity), .cfg_tristate(cfg_tristate),
        .cfg_cur_code(cfg_cur_code), .cfg_fastlock(cfg_fastlock),
        .cfg_pwrdn(cfg_pwrdn), .other_loop_off(other_loop_off),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_en(pump_en),
        .cur_code(cur_code), .fastlock_sw(fastlock_sw), .div_hold(div_hold),
        .section_off(section_off), .ref_osc_en(ref_osc_en)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic quiet_inputs();
        ref_div_in = 1'b0; vco_div_in = 1'b0;
        step(2);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(2); rst_n = 1'b1; #1;
        chk("R12", "pump_up", pump_up, 0);
        chk("R12", "pump_dn", pump_dn, 0);
        chk("R12", "pump_en", pump_en, 1);
        chk("R12", "section_off", section_off, 0);
        chk("R10", "ref_osc_en", ref_osc_en, 1);
        @(negedge clk);
    endtask

    task automatic t_detect();
        cfg_polarity = 1'b1;
        ref_div_in = 1'b1; step(1);
        chk("R1", "up after ref edge", pump_up, 1);
        chk("R1", "dn after ref edge", pump_dn, 0);
        step(1);
        chk("R1", "up held", pump_up, 1);
        vco_div_in = 1'b1; step(1);
        chk("R1", "dn after vco edge", pump_dn, 1);
        step(1);
        chk("R2", "up cleared", pump_up, 0);
        chk("R2", "dn cleared", pump_dn, 0);
        quiet_inputs();
    endtask

    task automatic t_polarity();
        cfg_polarity = 1'b0;
        vco_div_in = 1'b1; step(1);
        chk("R3", "swapped up", pump_up, 1);
        chk("R3", "swapped dn", pump_dn, 0);
        ref_div_in = 1'b1; step(2);
        chk("R3", "pair closed", pump_up | pump_dn, 0);
        cfg_polarity = 1'b1;
        quiet_inputs();
    endtask

    task automatic t_tristate();
        cfg_tristate = 1'b1;
        ref_div_in = 1'b1; step(1);
        chk("R4", "pump_en", pump_en, 0);
        chk("R4", "pump_up", pump_up, 0);
        cfg_tristate = 1'b0; #1;
        chk("R4", "up visible after release", pump_up, 1);
        vco_div_in = 1'b1; step(2);
        quiet_inputs();
    endtask

    task automatic t_current();
        cfg_cur_code = 3'd5; #1;
        chk("R5", "cur_code", cur_code, 5);
        chk("R5", "fastlock_sw", fastlock_sw, 0);
        cfg_fastlock = 1'b1; #1;
        chk("R6", "forced code", cur_code, 7);
        chk("R6", "switch on", fastlock_sw, 1);
        cfg_fastlock = 1'b0; #1;
        chk("R6", "restored code", cur_code, 5);
        cfg_cur_code = 3'd0; #1;
        chk("R5", "code zero", cur_code, 0);
        @(negedge clk);
    endtask

    task automatic t_async();
        cfg_tristate = 1'b1; cfg_pwrdn = 1'b1; #1;
        chk("R8", "section_off", section_off, 1);
        chk("R8", "div_hold", div_hold, 1);
        chk("R10", "osc on, other up", ref_osc_en, 1);
        other_loop_off = 1'b1; #1;
        chk("R10", "osc off, both down", ref_osc_en, 0);
        step(1);
        cfg_tristate = 1'b0; #1;
        chk("R8", "stays off", section_off, 1);
        cfg_pwrdn = 1'b0; #1;
        chk("R9", "section_off cleared", section_off, 0);
        chk("R9", "div_hold cleared", div_hold, 0);
        chk("R10", "osc back on", ref_osc_en, 1);
        other_loop_off = 1'b0;
        step(1);
    endtask

    task automatic t_sync_drain();
        ref_div_in = 1'b1; step(1);
        chk("R7", "pulse open", pump_up, 1);
        cfg_pwrdn = 1'b1; step(1);
        chk("R7", "pulse runs on", pump_up, 1);
        chk("R7", "pump still driven", pump_en, 1);
        step(2);
        chk("R7", "not off while busy", section_off, 0);
        vco_div_in = 1'b1; step(1);
        chk("R7", "pulse completes", pump_dn, 1);
        step(1);
        chk("R7", "pump driven after clear", pump_en, 1);
        chk("R7", "flags clear", pump_up | pump_dn, 0);
        step(1);
        chk("R7", "three-stated", pump_en, 0);
        chk("R7", "not yet off", section_off, 0);
        step(1);
        chk("R7", "section off", section_off, 1);
        chk("R7", "div_hold", div_hold, 1);
        cfg_pwrdn = 1'b0; #1;
        chk("R9", "restored", section_off, 0);
        quiet_inputs();
    endtask

    task automatic t_sync_block();
        ref_div_in = 1'b1; cfg_pwrdn = 1'b1; step(1);
        chk("R7", "no new pulse", pump_up, 0);
        chk("R7", "driven in drain", pump_en, 1);
        step(1);
        chk("R7", "three-stated", pump_en, 0);
        step(1);
        chk("R7", "off", section_off, 1);
        vco_div_in = 1'b1; step(2);
        chk("R11", "no output while off", pump_dn, 0);
        cfg_pwrdn = 1'b0; step(1);
        chk("R11", "nothing pending dn", pump_dn, 0);
        chk("R11", "nothing pending up", pump_up, 0);
        quiet_inputs();
        ref_div_in = 1'b1; step(1);
        chk("R1", "detector works again", pump_up, 1);
        vco_div_in = 1'b1; step(2);
        quiet_inputs();
    endtask

    initial begin
        t_reset();
        t_detect();
        t_polarity();
        t_tristate();
        t_current();
        t_async();
        t_sync_drain();
        t_sync_block();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule